// File: doc/BRIEF.md
# Adaptive Hold Controller with Timing-Error Retry

This block is the timing controller for a multiplier whose latency depends on its operands. When an operation is accepted, the controller counts the zero bits of one operand and compares that count with a threshold. Which operand it examines is fixed by a parameter: the multiplicand for a column-skipping array or the multiplier for a row-skipping array. Many zeros mean a short carry path, so the product is ready after one cycle. Otherwise the output registers are held for one extra cycle. The judgement runs in parallel with the datapath and is stored in a single flop that drives the capture enable of the result registers.

A wear flag from the chip replaces the normal threshold with a stricter one, so that a slowed circuit is given two cycles more often. During each capture cycle the controller compares the result word sampled on the main clock with the copy sampled by a late shadow stage, bit by bit. Any difference raises an error pulse and restarts the operation. The restarted operation always takes two cycles, whatever its operand. Upstream logic must keep the operands steady while `busy` or `retry` is high.

Top module: `vl_hold_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cap_en`, `busy`, `err` and `retry` are all 0.
- R2: A valid operation accepted with `aged`=0 whose examined operand has at least THR_NORM zero bits (4 for 8-bit operands) gives `cap_en`=1 and `busy`=1 in the cycle after acceptance.
- R3: An accepted operation below the applicable threshold gives `cap_en`=0 and `busy`=1 in the cycle after acceptance, then `cap_en`=1 and `busy`=1 in the following cycle.
- R4: With `aged`=1 at acceptance, the threshold becomes THR_AGED (5 for 8-bit operands). An operand with exactly 4 zeros then takes two cycles, and one with 5 zeros takes one.
- R5: With SEL_ROW=0 only `op_mcand` is examined, and the zero count of `op_mplier` has no effect on the latency. With SEL_ROW=1 the roles swap.
- R6: If `res_main` and `res_shadow` differ in any bit during a cycle with `cap_en`=1, `err` is 1 for exactly the next cycle.
- R7: In the cycle in which `err` is 1, `cap_en`=0, `busy`=1 and `retry`=1. In the cycle after that, `cap_en`=1 and `retry`=1. A mismatch in that second capture restarts the operation again.
- R8: A difference between `res_main` and `res_shadow` in a cycle with `cap_en`=0 has no effect: `err` stays 0 and the sequence continues unchanged.
- R9: `op_valid` is ignored while `busy`=1. No operation is accepted until the cycle after `cap_en` falls with no error.
- R10: The comparison covers all 2*OPW result bits. A single-bit difference at the least or the most significant position is detected.
- R11: After a capture cycle without mismatch, the next cycle has `cap_en`=0, `busy`=0 and `retry`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | New operation offered; taken when busy is 0 |
| op_mcand | input | OPW | Multiplicand |
| op_mplier | input | OPW | Multiplier |
| aged | input | 1 | Wear flag; selects the stricter threshold |
| res_main | input | 2*OPW | Result word sampled on the main clock |
| res_shadow | input | 2*OPW | Result word sampled by the late shadow stage |
| cap_en | output | 1 | Registered capture enable for the result registers |
| err | output | 1 | One-cycle timing-error pulse |
| retry | output | 1 | High while a restarted operation is in flight |
| busy | output | 1 | Operation in flight; new operations are refused |

## Verification
The collision that matters here is between a shadow mismatch in a capture cycle and a new `op_valid` offered in that same cycle. The bench holds `op_valid` high with a single-cycle operand while it corrupts one result bit during capture. It then checks that the controller restarts the old operation with the forced two-cycle pattern and does not accept the new one. It also moves mismatches into hold and idle cycles to confirm that they are masked there, and it raises a second error during the retry's own capture.

// File: rtl/vl_hold_pkg.sv
// Shared types for the variable-latency hold controller.
// Assumes nothing beyond a synthesizable enum encoding.
package vl_hold_pkg;
    // Controller phases: waiting for work, extra hold cycle, capture cycle.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOLD = 2'd1,
        PH_CAP  = 2'd2
    } phase_t;
endpackage

// File: rtl/vl_zero_count.sv
// Counts the zero bits of an operand word.
// Assumes CW is wide enough to hold the value W.
module vl_zero_count #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  word,
    output logic [CW-1:0] zeros
);
    // Adds one for each cleared bit.
    always_comb begin
        zeros = '0;
        for (int i = 0; i < W; i++) begin
            zeros = zeros + CW'(!word[i]);
        end
    end
endmodule

// File: rtl/vl_judge.sv
// Judging block: reports that one cycle is enough when the zero count
// reaches its threshold. Assumes THR fits in CW bits.
module vl_judge #(
    parameter int CW  = 4,
    parameter int THR = 4
) (
    input  logic [CW-1:0] zeros,
    output logic          one_cycle
);
    localparam logic [CW:0] THR_V = (CW+1)'(THR);

    // Compares the count, widened by one bit, with the threshold.
    always_comb one_cycle = ({1'b0, zeros} >= THR_V);
endmodule

// File: rtl/vl_shadow_cmp.sv
// Compares the main and shadow result samples bit by bit and flags any
// difference. Assumes both words are aligned to the same result bit.
module vl_shadow_cmp #(
    parameter int RW = 16
) (
    input  logic [RW-1:0] main_w,
    input  logic [RW-1:0] shad_w,
    output logic          mismatch
);
    logic [RW-1:0] diff;

    // One XOR per result bit.
    for (genvar b = 0; b < RW; b++) begin : g_bit
        assign diff[b] = main_w[b] ^ shad_w[b];
    end

    // Any differing bit is a timing error.
    assign mismatch = |diff;
endmodule

// File: rtl/vl_hold_ctrl.sv
// Adaptive hold controller for a variable-latency multiplier.
// Counts the zeros of the operand chosen by SEL_ROW and judges it against
// the normal or the aged threshold. It then drives a registered capture
// enable: one cycle for easy operands, two for hard ones. During each
// capture cycle it compares the main and shadow samples, and on a
// difference it restarts the operation with forced two-cycle latency.
// Assumes upstream keeps the operands steady while busy or retry is high.
module vl_hold_ctrl
    import vl_hold_pkg::*;
#(
    parameter int OPW      = 8,
    parameter bit SEL_ROW  = 1'b0,
    parameter int THR_NORM = OPW / 2,
    parameter int THR_AGED = OPW / 2 + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OPW-1:0]   op_mcand,
    input  logic [OPW-1:0]   op_mplier,
    input  logic             aged,
    input  logic [2*OPW-1:0] res_main,
    input  logic [2*OPW-1:0] res_shadow,
    output logic             cap_en,
    output logic             err,
    output logic             retry,
    output logic             busy
);
    localparam int RW = 2 * OPW;
    localparam int CW = $clog2(OPW + 1);
    localparam int THR_TAB [2] = '{THR_NORM, THR_AGED};

    logic [OPW-1:0] opnd;
    logic [CW-1:0]  zeros;
    logic [1:0]     fast_vec;
    logic           fast;
    logic           mismatch;

    phase_t ph_q, ph_n;
    logic   cap_q, busy_q, err_q, retry_q;
    logic   err_n, retry_n;

    // Picks the operand whose zeros decide the latency.
    always_comb opnd = SEL_ROW ? op_mplier : op_mcand;

    vl_zero_count #(.W(OPW), .CW(CW)) u_cnt (
        .word  (opnd),
        .zeros (zeros)
    );

    // Judging blocks: index 0 normal, index 1 aged.
    for (genvar g = 0; g < 2; g++) begin : g_judge
        vl_judge #(.CW(CW), .THR(THR_TAB[g])) u_judge (
            .zeros     (zeros),
            .one_cycle (fast_vec[g])
        );
    end

    // The wear flag selects the judging block.
    always_comb fast = aged ? fast_vec[1] : fast_vec[0];

    vl_shadow_cmp #(.RW(RW)) u_cmp (
        .main_w   (res_main),
        .shad_w   (res_shadow),
        .mismatch (mismatch)
    );

    // Next phase, error and retry decisions.
    always_comb begin
        ph_n    = ph_q;
        err_n   = 1'b0;
        retry_n = retry_q;
        case (ph_q)
            PH_IDLE: begin
                retry_n = 1'b0;
                if (op_valid) begin
                    ph_n = fast ? PH_CAP : PH_HOLD;
                end
            end
            PH_HOLD: begin
                ph_n = PH_CAP;
            end
            PH_CAP: begin
                if (mismatch) begin
                    ph_n    = PH_HOLD;
                    err_n   = 1'b1;
                    retry_n = 1'b1;
                end else begin
                    ph_n    = PH_IDLE;
                    retry_n = 1'b0;
                end
            end
            default: begin
                ph_n    = PH_IDLE;
                retry_n = 1'b0;
            end
        endcase
    end

    // Registers phase and outputs; the capture enable is the hold flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            cap_q   <= 1'b0;
            busy_q  <= 1'b0;
            err_q   <= 1'b0;
            retry_q <= 1'b0;
        end else begin
            ph_q    <= ph_n;
            cap_q   <= (ph_n == PH_CAP);
            busy_q  <= (ph_n != PH_IDLE);
            err_q   <= err_n;
            retry_q <= retry_n;
        end
    end

    assign cap_en = cap_q;
    assign busy   = busy_q;
    assign err    = err_q;
    assign retry  = retry_q;
endmodule

// File: rtl/vl_hold_chk.sv
// Property checker for the hold controller, attached by bind.
// Observes only the top-level handshake and status ports.
module vl_hold_chk (
    input logic clk,
    input logic rst_n,
    input logic op_valid,
    input logic cap_en,
    input logic busy,
    input logic err,
    input logic retry
);
    AST_HOLD_THEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cap_en) |=> cap_en); // R3
    AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> !cap_en); // R11
    AST_ERR_AFTER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(cap_en)); // R8
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R6
    AST_RETRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!cap_en && busy && retry)); // R7
    AST_RETRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (cap_en && retry)); // R7
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !op_valid) |=> !busy); // R9
    AST_CAP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> busy); // R2
endmodule

bind vl_hold_ctrl vl_hold_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .cap_en   (cap_en),
    .busy     (busy),
    .err      (err),
    .retry    (retry)
);

// File: tb/sim_vl_hold_ctrl.sv
// Directed bench for the hold controller; 50 MHz clock, default parameters.
module sim_vl_hold_ctrl;
    localparam int OPW = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_valid = 1'b0;
    logic [OPW-1:0]   op_mcand = '0;
    logic [OPW-1:0]   op_mplier = '0;
    logic             aged = 1'b0;
    logic [2*OPW-1:0] res_main = 16'h5A3C;
    logic [2*OPW-1:0] res_shadow = 16'h5A3C;
    logic             cap_en, err, retry, busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vl_hold_ctrl #(.OPW(OPW)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
        .op_mcand(op_mcand), .op_mplier(op_mplier), .aged(aged),
        .res_main(res_main), .res_shadow(res_shadow),
        .cap_en(cap_en), .err(err), .retry(retry), .busy(busy)
    );

    // Compares {cap_en,busy,err,retry} with the expected value.
    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {cap_en, busy, err, retry};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cap/busy/err/retry act=%b exp=%b", tag, act, exp);
        end
    endtask

    // Offers one operation at a falling edge; returns after it is taken.
    task automatic offer(input logic [OPW-1:0] mc, input logic [OPW-1:0] mp, input logic ag);
        op_mcand = mc; op_mplier = mp; aged = ag; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); chk("R1 in reset", 4'b0000);
        rst_n = 1'b1;
        @(negedge clk); chk("R1 after reset", 4'b0000);
    endtask

    task automatic t_fast();
        offer(8'b1111_0000, 8'hFF, 1'b0); chk("R2 four zeros", 4'b1100);
        @(negedge clk); chk("R11 back to idle", 4'b0000);
        offer(8'h00, 8'hFF, 1'b0); chk("R2 all zeros", 4'b1100);
        @(negedge clk); chk("R11 idle", 4'b0000);
    endtask

    task automatic t_slow();
        offer(8'b1111_1000, 8'h00, 1'b0); chk("R3 hold cycle", 4'b0100);
        @(negedge clk); chk("R3 capture cycle", 4'b1100);
        @(negedge clk); chk("R11 idle after slow", 4'b0000);
    endtask

    task automatic t_aged();
        offer(8'b1111_0000, 8'h00, 1'b1); chk("R4 four zeros aged hold", 4'b0100);
        @(negedge clk); chk("R4 aged capture", 4'b1100);
        @(negedge clk);
        offer(8'b1110_0000, 8'h00, 1'b1); chk("R4 five zeros aged fast", 4'b1100);
        @(negedge clk); chk("R4 idle", 4'b0000);
    endtask

    task automatic t_opsel();
        offer(8'hFF, 8'h00, 1'b0); chk("R5 mplier zeros ignored", 4'b0100);
        @(negedge clk); chk("R5 capture", 4'b1100);
        @(negedge clk);
        offer(8'h00, 8'hFF, 1'b0); chk("R5 mcand decides", 4'b1100);
        @(negedge clk);
    endtask

    // A single-bit mismatch at position pos during capture restarts the operation.
    task automatic t_error(input int pos, input string tag);
        offer(8'h0F, 8'h00, 1'b0);
        chk({tag, " capture"}, 4'b1100);
        res_shadow = res_main ^ (16'h1 << pos);
        @(negedge clk); res_shadow = res_main;
        chk({tag, " R6 R7 err cycle"}, 4'b0111);
        @(negedge clk); chk({tag, " R7 retry capture"}, 4'b1101);
        @(negedge clk); chk({tag, " R11 idle after retry"}, 4'b0000);
    endtask

    task automatic t_error_twice();
        offer(8'h0F, 8'h00, 1'b0);
        res_shadow = ~res_main;
        @(negedge clk); res_shadow = res_main;
        chk("R6 first err", 4'b0111);
        @(negedge clk); chk("R7 retry capture", 4'b1101);
        res_shadow = res_main ^ 16'h0100;
        @(negedge clk); res_shadow = res_main;
        chk("R7 second err", 4'b0111);
        @(negedge clk); chk("R7 second retry capture", 4'b1101);
        @(negedge clk); chk("R11 idle", 4'b0000);
    endtask

    task automatic t_masked();
        res_shadow = ~res_main;
        @(negedge clk); chk("R8 idle mismatch", 4'b0000);
        res_shadow = res_main;
        offer(8'hFF, 8'h00, 1'b0); chk("R3 hold", 4'b0100);
        res_shadow = ~res_main;
        @(negedge clk); res_shadow = res_main;
        chk("R8 hold mismatch masked", 4'b1100);
        @(negedge clk); chk("R8 no err", 4'b0000);
    endtask

    // A new op offered during hold and capture, colliding with a mismatch.
    task automatic t_collide();
        offer(8'hFF, 8'h00, 1'b0); chk("R3 hold", 4'b0100);
        op_mcand = 8'h00; op_valid = 1'b1;
        @(negedge clk); chk("R9 valid in hold ignored", 4'b1100);
        res_shadow = res_main ^ 16'h0004;
        @(negedge clk); res_shadow = res_main;
        chk("R9 R6 collision err wins", 4'b0111);
        @(negedge clk); chk("R9 R7 retry capture", 4'b1101);
        op_valid = 1'b0;
        @(negedge clk); chk("R9 no accept while busy", 4'b0000);
    endtask

    initial begin
        t_reset();
        t_fast();
        t_slow();
        t_aged();
        t_opsel();
        t_error(0, "R10 lsb");
        t_error(2*OPW-1, "R10 msb");
        t_error_twice();
        t_masked();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule